// File: doc/BRIEF.md
# Instruction Prefetch and Decode Front End

This block sits at the head of a processor pipeline. It keeps a small FIFO of prefetched instruction words topped up by asking memory for aligned 8-byte doublewords. Words returned by memory enter the FIFO in address order, lower word first. One word per cycle leaves the FIFO into an extract register, and the next cycle it sits in a decode register. From decode it is sent to the fixed-point or the floating-point operation queue, or it is executed on the spot when it is a branch.

Decode waits when the queue it targets reports full, and while a conditional branch is unresolved. An arithmetic word that names a memory operand is also split off into a separate operand reference. That reference spends one cycle in an address stage and then appears at its own output. An unconditional branch redirects fetch at once. A conditional branch sets an interlock that halts fetch and decode until a resolve pulse reports the outcome. A taken outcome discards every buffered and in-flight word and refetches from the branch target.

Instruction word format (32 bits): bit 31 set marks a branch. For an arithmetic word, bit 30 selects the queue (0 fixed-point, 1 floating-point) and bit 29 marks a memory operand. For a branch, bit 29 marks it conditional. Bits 15:0 hold the operand address or the branch target byte address. The low three bits of a target are ignored, so a target is always aligned to a doubleword.

Top module: `ifront_top`

## Requirements
- R1: While reset is held and on the first cycle after it, fetch_req_o is 1 with fetch_addr_o equal to the reset address (0 by default), and fx_push_o, fl_push_o and opref_valid_o are 0.
- R2: At most one fetch request is issued per cycle. Along a straight-line stream, each request address is the previous one plus 8.
- R3: A fetch is issued only if the buffer (16 words by default) can take one more doubleword once all outstanding fills are counted. With both queues held full from reset, exactly 9 doublewords are fetched: 16 buffered words, plus one word each in the extract and decode registers.
- R4: No fetch request is issued while a conditional branch interlock is pending.
- R5: A word accepted from memory at clock edge E can be dispatched no earlier than the cycle after edge E+2. This is one cycle of extract and one of decode.
- R6: Arithmetic words leave in program order, one per cycle at most. Bit 30 = 0 goes to fx_push_o and bit 30 = 1 goes to fl_push_o, never both at once, with the word on disp_instr_o.
- R7: While the target queue's full input is high, that word is held in decode and not pushed, and nothing behind it overtakes it or is lost.
- R8: A dispatched word with bit 29 = 1 (arithmetic) produces opref_valid_o in the following cycle, with opref_addr_o equal to its bits 15:0. No reference is produced otherwise.
- R9: Branch words (bit 31 = 1) are never pushed to a queue. An unconditional branch (bit 29 = 0) redirects fetch to its target and discards every buffered and in-flight word.
- R10: A conditional branch (bit 29 = 1) holds decode until resolve_valid_i. A not-taken outcome resumes at the next sequential word. A taken outcome discards pending words and resumes at the target.
- R11: resolve_valid_i has no effect when no conditional branch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_req_o | output | 1 | Doubleword fetch request this cycle |
| fetch_addr_o | output | ADDR_W | Byte address of the requested doubleword |
| fill_valid_i | input | 1 | Memory returns a doubleword, in request order |
| fill_data_i | input | 64 | Returned doubleword, lower address in bits 31:0 |
| fx_full_i | input | 1 | Fixed-point operation queue is full |
| fl_full_i | input | 1 | Floating-point operation queue is full |
| fx_push_o | output | 1 | Push disp_instr_o into the fixed-point queue |
| fl_push_o | output | 1 | Push disp_instr_o into the floating-point queue |
| disp_instr_o | output | 32 | Word being dispatched |
| opref_valid_o | output | 1 | Operand memory reference valid |
| opref_addr_o | output | ADDR_W | Operand reference byte address |
| resolve_valid_i | input | 1 | Outcome of the pending conditional branch |
| resolve_taken_i | input | 1 | 1 when that branch is taken |

## Verification
On every cycle, the assertions check that the buffer can neither overflow nor underflow and that no fetch leaves while the interlock is set. They also check that a stalled decode word holds steady, that a push never meets a full queue, that a branch never reaches a queue, and that each operand reference follows a memory-operand dispatch. Only the bench scenarios can show that words arrive in program order across redirects and across the dropping of in-flight fills. The same holds for the exact fetch count under a full stall, the two-cycle extract and decode latency, and that a resolve pulse with nothing pending changes nothing.

// File: rtl/ifront_pkg.sv
package ifront_pkg;
  typedef logic [31:0] word_t;
  typedef enum logic [1:0] {CLS_FX, CLS_FL, CLS_BR} cls_e;
  typedef struct packed {
    cls_e        cls;
    logic        mem_op;
    logic        cond;
    logic [15:0] imm;
  } dec_t;

  function automatic dec_t decode_word(word_t w);
    dec_t d;
    d.cls    = w[31] ? CLS_BR : (w[30] ? CLS_FL : CLS_FX);
    d.mem_op = !w[31] && w[29];
    d.cond   = w[31] && w[29];
    d.imm    = w[15:0];
    return d;
  endfunction
endpackage

// File: rtl/ifront_fetch.sv
module ifront_fetch #(
  parameter int ADDR_W = 16,
  parameter int BUF_WORDS = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [$clog2(BUF_WORDS+1)-1:0] buf_cnt_i,
  input  logic                          lock_i,
  input  logic                          flush_i,
  input  logic [ADDR_W-1:0]             redirect_i,
  input  logic                          fill_valid_i,
  output logic                          req_o,
  output logic [ADDR_W-1:0]             addr_o,
  output logic                          accept_fill_o
);
  localparam int CNT_W = $clog2(BUF_WORDS+1);

  logic [CNT_W-1:0]  inflight_q, drop_q, live;
  logic [ADDR_W-1:0] pc_q;
  logic              room;

  assign live = inflight_q - drop_q;

  // credit check: buffered words plus words still owed by memory
  always_comb begin
    room = (int'(buf_cnt_i) + 2 * int'(live) + 2) <= BUF_WORDS;
  end

  assign req_o         = room && !lock_i && !flush_i;
  assign addr_o        = pc_q;
  assign accept_fill_o = fill_valid_i && (drop_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= RESET_ADDR;
      inflight_q <= '0;
      drop_q     <= '0;
    end else begin
      inflight_q <= inflight_q + CNT_W'(req_o) - CNT_W'(fill_valid_i);
      if (flush_i) begin
        drop_q <= inflight_q - CNT_W'(fill_valid_i);
        pc_q   <= {redirect_i[ADDR_W-1:3], 3'b000};
      end else begin
        if (fill_valid_i && drop_q != '0) drop_q <= drop_q - CNT_W'(1);
        if (req_o) pc_q <= pc_q + ADDR_W'(8);
      end
    end
  end

  AST_OCCUPANCY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(buf_cnt_i) + 2 * int'(live)) <= BUF_WORDS); // R3
  AST_PC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> (pc_q[2:0] == 3'b000)); // R9
endmodule

// File: rtl/ifront_ibuf.sv
module ifront_ibuf #(
  parameter int BUF_WORDS = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          push2_i,
  input  logic [63:0]                   data_i,
  input  logic                          pop_i,
  output logic [31:0]                   head_o,
  output logic                          empty_o,
  output logic [$clog2(BUF_WORDS+1)-1:0] cnt_o
);
  localparam int PTR_W = $clog2(BUF_WORDS);
  localparam int CNT_W = $clog2(BUF_WORDS+1);

  logic [31:0]      mem_q [BUF_WORDS];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push2_i) begin
      mem_q[wp_q]               <= data_i[31:0];
      mem_q[wp_q + PTR_W'(1)]   <= data_i[63:32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push2_i) wp_q <= wp_q + PTR_W'(2);
      if (pop_i)   rp_q <= rp_q + PTR_W'(1);
      cnt_q <= cnt_q + (push2_i ? CNT_W'(2) : '0) - CNT_W'(pop_i);
    end
  end

  assign head_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;

  AST_IBUF_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push2_i |-> (int'(cnt_q) + 2 - int'(pop_i)) <= BUF_WORDS); // R3
  AST_IBUF_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0); // R6
endmodule

// File: rtl/ifront_decode.sv
module ifront_decode
  import ifront_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  word_t             head_i,
  input  logic              empty_i,
  input  logic              fx_full_i,
  input  logic              fl_full_i,
  input  logic              resolve_valid_i,
  input  logic              resolve_taken_i,
  output logic              pop_o,
  output logic              fx_push_o,
  output logic              fl_push_o,
  output word_t             disp_o,
  output logic              agen_req_o,
  output logic [ADDR_W-1:0] agen_addr_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] redirect_o,
  output logic              lock_o
);
  logic              x_valid_q, d_valid_q, lock_q;
  word_t             x_word_q, d_word_q;
  logic [ADDR_W-1:0] lock_tgt_q;
  dec_t              d;
  logic              is_br, tgt_full, fire, br_flush, res_flush, d_ready, x_ready;

  assign d        = decode_word(d_word_q);
  assign is_br    = (d.cls == CLS_BR);
  assign tgt_full = (d.cls == CLS_FL) ? fl_full_i : fx_full_i;
  assign fire     = d_valid_q && !lock_q && (is_br || !tgt_full);

  assign br_flush  = fire && is_br && !d.cond;
  assign res_flush = lock_q && resolve_valid_i && resolve_taken_i;
  assign flush_o   = br_flush || res_flush;
  assign redirect_o = res_flush ? lock_tgt_q : ADDR_W'(d.imm);

  assign d_ready = !d_valid_q || fire;
  assign x_ready = !x_valid_q || d_ready;
  assign pop_o   = !empty_i && x_ready && !flush_o;

  assign fx_push_o   = fire && (d.cls == CLS_FX);
  assign fl_push_o   = fire && (d.cls == CLS_FL);
  assign disp_o      = d_word_q;
  assign agen_req_o  = fire && d.mem_op;
  assign agen_addr_o = ADDR_W'(d.imm);
  assign lock_o      = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_valid_q  <= 1'b0;
      d_valid_q  <= 1'b0;
      x_word_q   <= '0;
      d_word_q   <= '0;
      lock_q     <= 1'b0;
      lock_tgt_q <= '0;
    end else begin
      if (flush_o) begin
        x_valid_q <= 1'b0;
        d_valid_q <= 1'b0;
      end else begin
        if (d_ready) begin
          d_valid_q <= x_valid_q;
          d_word_q  <= x_word_q;
        end
        if (x_ready) begin
          x_valid_q <= pop_o;
          x_word_q  <= head_i;
        end
      end
      // resolve only counts while a branch is pending
      if (lock_q && resolve_valid_i) begin
        lock_q <= 1'b0;
      end else if (fire && is_br && d.cond) begin
        lock_q     <= 1'b1;
        lock_tgt_q <= ADDR_W'(d.imm);
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_q && !fire && !flush_o) |=> (d_valid_q && $stable(d_word_q))); // R7
  AST_LOCK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && resolve_valid_i) |=> !lock_q); // R10
  AST_BR_NOT_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fx_push_o || fl_push_o) |-> !disp_o[31]); // R9
endmodule

// File: rtl/ifront_agen.sv
module ifront_agen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) addr_o <= addr_i;
    end
  end

  AST_OPREF_AFTER_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(req_i)); // R8
endmodule

// File: rtl/ifront_top.sv
module ifront_top
  import ifront_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUF_BYTES = 64,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fill_valid_i,
  input  logic [63:0]       fill_data_i,
  input  logic              fx_full_i,
  input  logic              fl_full_i,
  output logic              fx_push_o,
  output logic              fl_push_o,
  output logic [31:0]       disp_instr_o,
  output logic              opref_valid_o,
  output logic [ADDR_W-1:0] opref_addr_o,
  input  logic              resolve_valid_i,
  input  logic              resolve_taken_i
);
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int CNT_W = $clog2(BUF_WORDS+1);

  logic [CNT_W-1:0]  buf_cnt;
  logic              lock, flush, accept_fill, pop, empty, agen_req;
  logic [ADDR_W-1:0] redirect, agen_addr;
  word_t             head;

  ifront_fetch #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk_i, .rst_ni,
    .buf_cnt_i     (buf_cnt),
    .lock_i        (lock),
    .flush_i       (flush),
    .redirect_i    (redirect),
    .fill_valid_i,
    .req_o         (fetch_req_o),
    .addr_o        (fetch_addr_o),
    .accept_fill_o (accept_fill)
  );

  ifront_ibuf #(.BUF_WORDS(BUF_WORDS)) u_ibuf (
    .clk_i, .rst_ni,
    .flush_i (flush),
    .push2_i (accept_fill && !flush),
    .data_i  (fill_data_i),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .cnt_o   (buf_cnt)
  );

  ifront_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i, .rst_ni,
    .head_i          (head),
    .empty_i         (empty),
    .fx_full_i, .fl_full_i,
    .resolve_valid_i, .resolve_taken_i,
    .pop_o           (pop),
    .fx_push_o, .fl_push_o,
    .disp_o          (disp_instr_o),
    .agen_req_o      (agen_req),
    .agen_addr_o     (agen_addr),
    .flush_o         (flush),
    .redirect_o      (redirect),
    .lock_o          (lock)
  );

  ifront_agen #(.ADDR_W(ADDR_W)) u_agen (
    .clk_i, .rst_ni,
    .req_i   (agen_req),
    .addr_i  (agen_addr),
    .valid_o (opref_valid_o),
    .addr_o  (opref_addr_o)
  );

  AST_NO_FETCH_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> !fetch_req_o); // R4
  AST_FX_FULL_RESPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fx_push_o |-> !fx_full_i); // R7
  AST_FL_FULL_RESPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_push_o |-> !fl_full_i); // R7
  AST_ONE_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fx_push_o, fl_push_o})); // R6
endmodule

// File: tb/ifront_top_test.sv
`timescale 1ns/1ps
module ifront_top_test;
  localparam int LAT = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_req_o;
  logic [15:0] fetch_addr_o;
  logic        fill_valid_i = 1'b0;
  logic [63:0] fill_data_i = '0;
  logic        fx_full_i = 1'b0, fl_full_i = 1'b0;
  logic        fx_push_o, fl_push_o;
  logic [31:0] disp_instr_o;
  logic        opref_valid_o;
  logic [15:0] opref_addr_o;
  logic        resolve_valid_i = 1'b0, resolve_taken_i = 1'b0;

  ifront_top uut (.*);

  always #4 clk_i = !clk_i;

  logic [31:0] mem [256];
  bit          pv [16];
  logic [15:0] pa [16];
  int n_chk, n_fail, step;
  int exp_idx, first_push, n_push, n_fetch, win_push, win_fetch;
  int full_until, res_a, res_b, res_per, win_lo, win_hi;
  bit fx_pat, fl_pat, sc_taken, seq_chk, have_fa, op_exp, done;
  logic [15:0] last_fa, op_addr_exp;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (step %0d)", req, act, expv, step);
    end
  endtask

  function automatic logic [31:0] mk_ar(bit fl, bit mo, int imm);
    return {1'b0, fl, mo, 13'h0, 16'(imm)};
  endfunction
  function automatic logic [31:0] mk_br(bit cnd, int tgt);
    return {1'b1, 1'b0, cnd, 13'h0, 16'(tgt)};
  endfunction
  function automatic int tgt_idx(logic [31:0] w);
    return (int'(w[15:3]) * 2) & 255;
  endfunction

  task automatic fill_straight();
    for (int w = 0; w < 256; w++) mem[w] = mk_ar(w % 3 == 1, w % 4 == 1, 16'h100 + w * 4);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    fill_valid_i = 1'b0; resolve_valid_i = 1'b0; fx_full_i = 1'b0; fl_full_i = 1'b0;
    for (int i = 0; i < 16; i++) pv[i] = 1'b0;
    step = 0; exp_idx = 0; first_push = -1; n_push = 0; n_fetch = 0;
    win_push = 0; win_fetch = 0; have_fa = 0; op_exp = 0;
    full_until = 0; res_a = -1; res_b = -1; res_per = 0; win_lo = -1; win_hi = -1;
    fx_pat = 0; fl_pat = 0; sc_taken = 0; seq_chk = 0;
    @(negedge clk_i); @(negedge clk_i);
    chk(fetch_req_o == 1'b1, "R1 req in reset", fetch_req_o, 1);
    chk(fetch_addr_o == 16'h0, "R1 addr in reset", fetch_addr_o, 0);
    chk(!fx_push_o && !fl_push_o && !opref_valid_o, "R1 idle", {fx_push_o, fl_push_o, opref_valid_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic one_step();
    int slot, idx;
    logic [31:0] w;
    fx_full_i = (step < full_until) || (fx_pat && step % 5 == 2);
    fl_full_i = (step < full_until) || (fl_pat && step % 7 == 3);
    resolve_valid_i = (step == res_a) || (step == res_b) ||
                      (res_per != 0 && step % res_per == res_per - 1);
    resolve_taken_i = sc_taken;
    slot = step & 15;
    fill_valid_i = pv[slot];
    idx = (int'(pa[slot]) >> 2) & 255;
    fill_data_i = {mem[(idx + 1) & 255], mem[idx]};
    pv[slot] = 1'b0;
    #1;
    chk(opref_valid_o == op_exp, "R8 opref valid", opref_valid_o, op_exp);
    if (op_exp) chk(opref_addr_o == op_addr_exp, "R8 opref addr", opref_addr_o, op_addr_exp);
    op_exp = 0;
    if (fetch_req_o) begin
      pv[(step + LAT) & 15] = 1'b1;
      pa[(step + LAT) & 15] = fetch_addr_o;
      n_fetch++;
      if (step >= win_lo && step <= win_hi) win_fetch++;
      if (seq_chk && have_fa) chk(fetch_addr_o == last_fa + 16'd8, "R2 fetch step", fetch_addr_o, last_fa + 16'd8);
      last_fa = fetch_addr_o; have_fa = 1;
    end
    if (fx_push_o || fl_push_o) begin
      n_push++;
      if (first_push < 0) first_push = step;
      if (step >= win_lo && step <= win_hi) win_push++;
      chk(!(fx_push_o && fx_full_i) && !(fl_push_o && fl_full_i), "R7 push into full", {fx_push_o, fl_push_o}, 0);
      chk(!disp_instr_o[31], "R9 branch dispatched", disp_instr_o, 0);
      for (int k = 0; k < 8; k++) begin
        w = mem[exp_idx];
        if (!w[31]) break;
        if (w[29] && !sc_taken) exp_idx = (exp_idx + 1) & 255;
        else exp_idx = tgt_idx(w);
      end
      w = mem[exp_idx];
      chk(disp_instr_o == w, "R6 order/R10 resume", disp_instr_o, w);
      chk(fx_push_o == !w[30], "R6 routing", {fx_push_o, fl_push_o}, {!w[30], w[30]});
      if (w[29]) begin op_exp = 1; op_addr_exp = w[15:0]; end
      exp_idx = (exp_idx + 1) & 255;
    end
    @(negedge clk_i);
    step++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) one_step();
  endtask

  initial begin
    // straight line with queue-full pulses
    fill_straight();
    do_reset();
    fx_pat = 1; fl_pat = 1; seq_chk = 1;
    run(120);
    chk(first_push == LAT + 3, "R5 first dispatch", first_push, LAT + 3);
    chk(n_push >= 40, "R6 progress", n_push, 40);

    // both queues full: credit limit
    do_reset();
    full_until = 40;
    run(40);
    chk(n_fetch == 9, "R3 fetch count", n_fetch, 9);
    chk(n_push == 0, "R7 held while full", n_push, 0);
    run(60);
    chk(n_push >= 30, "R7 release", n_push, 30);

    // unconditional branches
    fill_straight();
    mem[5] = mk_br(0, 80);
    mem[25] = mk_br(0, 32);
    do_reset();
    fx_pat = 1;
    run(150);
    chk(n_push >= 60, "R9 progress", n_push, 60);

    // conditional not taken, periodic resolve
    fill_straight();
    mem[3] = mk_br(1, 160);
    mem[11] = mk_br(1, 200);
    mem[20] = mk_br(0, 0);
    do_reset();
    res_per = 25; sc_taken = 0;
    run(150);
    chk(n_push >= 30, "R10 not-taken progress", n_push, 30);

    // conditional taken, long wait, spurious early resolve
    fill_straight();
    mem[1] = mk_br(1, 160);
    do_reset();
    sc_taken = 1; res_a = 4; res_b = 60; win_lo = 20; win_hi = 59;
    run(20);
    chk(n_push == 1, "R11 early resolve ignored", n_push, 1);
    run(40);
    chk(win_fetch == 0, "R4 no fetch locked", win_fetch, 0);
    chk(win_push == 0, "R10 decode held", win_push, 0);
    run(40);
    chk(n_push >= 10, "R10 taken resume", n_push, 10);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule